// File: doc/BRIEF.md
# Multi-Mode Planar Pixel Shifter

This block turns one 32-bit display word into a stream of eight 4-bit pixel values, one per dot clock. The word holds four 8-bit planes: plane 0 sits in bits 7:0, plane 1 in bits 15:8, plane 2 in bits 23:16 and plane 3 in bits 31:24. The fetch logic offers words through a valid/ready handshake. The shifter accepts the next word in the same cycle that it shows the last pixel of the current word, so back-to-back words produce an unbroken pixel stream.

Three mappings from planes to pixels are available. Planar mode takes one bit from each plane per pixel. Packed mode pairs two bits from a low plane with two bits from the high plane two positions above it. Wide mode emits whole nibbles, walking through the planes in order; one variant sends the high nibble of each plane first and the other sends the low nibble first. The mode inputs are sampled only when a word is accepted, and that mapping then stays fixed for all eight pixels of the word.

Top module: `plane_pixel_shifter`

## Requirements
- R1: After reset, pixValid is 0, pixOut is 0 and wordReady is 1.
- R2: With modeWide=0 and modeInterleave=0 (planar), pixel k (k=0..7) has bit n equal to bit (7-k) of plane n.
- R3: With modeWide=0 and modeInterleave=1 (packed), pixels 0-3 use low plane 0 and high plane 2, and pixels 4-7 use low plane 1 and high plane 3. Pixel k is {high[7-2j:6-2j], low[7-2j:6-2j]} with j=k mod 4.
- R4: With modeWide=1 and nibbleRight=0, pixel k is bits 7:4 of plane k/2 when k is even and bits 3:0 of that plane when k is odd.
- R5: With modeWide=1 and nibbleRight=1, pixel k is bits 3:0 of plane k/2 when k is even and bits 7:4 of that plane when k is odd.
- R6: When modeWide=1, the value of modeInterleave has no effect on the output.
- R7: Each accepted word gives exactly 8 consecutive valid pixels. wordReady is high while the 8th pixel is shown, and a word accepted then is followed by its first pixel with no invalid cycle in between.
- R8: A change on modeWide, modeInterleave or nibbleRight while a word is being shifted does not change the pixels of that word.
- R9: When no word is being shifted, pixValid is 0 and pixOut is 0. Without a new word after the 8th pixel, the next cycle is idle.
- R10: A word offered while wordReady is low is not consumed until wordReady goes high, and it does not disturb the word that is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | A display word is offered |
| wordData | input | 32 | Display word, plane n in bits 8n+7:8n |
| wordReady | output | 1 | The shifter takes the offered word at this edge |
| modeWide | input | 1 | Selects 4-bit nibble mode; takes precedence over interleave |
| modeInterleave | input | 1 | Selects packed two-plane mode |
| nibbleRight | input | 1 | In nibble mode, sends the low nibble of each plane first |
| pixOut | output | 4 | Current pixel value |
| pixValid | output | 1 | pixOut holds a pixel of an accepted word |

## Verification
Two functions can fall in the same cycle: the 8th pixel of one word is shown while the next word is loaded, and the mode inputs change at that point. The driver offers each following word, with different mode settings, while the current word is still being shifted. Correct behaviour means the current word finishes with its own mapping, valid never drops between the two words, and the new word starts with its own mapping. A monitor compares every pixel against a queue of expected values, so a shortened word, an extra pixel or a mapping taken from the wrong mode settings shows up as a mismatch or as an invalid cycle while the queue still holds pixels.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int PLANES     = 4;
  localparam int PLANE_BITS = 8;
  localparam int PIX_W      = 4;
  localparam int WORD_W     = PLANES * PLANE_BITS;
  localparam int SLOT_W     = $clog2(PLANE_BITS);

  typedef enum logic [1:0] {
    SH_PLANAR = 2'd0,
    SH_PACKED = 2'd1,
    SH_WIDE_L = 2'd2,
    SH_WIDE_R = 2'd3
  } shiftMode_e;

  typedef struct packed {
    logic              load;
    logic              active;
    logic [SLOT_W-1:0] slot;
  } shiftCtl_t;
endpackage

// File: rtl/pxs_ctrl.sv
module pxs_ctrl
  import pxs_pkg::*;
#(
  parameter int SLOTS = PLANE_BITS
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wordValid,
  output logic      wordReady,
  output shiftCtl_t ctl
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic              active;
  logic [SLOT_W-1:0] slot;
  logic              accept;

  assign wordReady = !active || (slot == LAST);
  assign accept    = wordValid && wordReady;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      slot   <= '0;
    end else if (accept) begin
      active <= 1'b1;
      slot   <= '0;
    end else if (active) begin
      if (slot == LAST) begin
        active <= 1'b0;
        slot   <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  assign ctl.load   = accept;
  assign ctl.active = active;
  assign ctl.slot   = slot;

  // R7: an accepted word always starts at slot 0 on the next cycle
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (active && slot == '0));

  // R7: inside a word the slot advances by one each cycle
  p_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && slot != LAST) |=> (active && slot == $past(slot) + 1'b1));

  // R9: the last slot with no new word leads to an idle cycle
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && slot == LAST && !wordValid) |=> !active);
endmodule

// File: rtl/pxs_datapath.sv
module pxs_datapath
  import pxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  shiftCtl_t         ctl,
  input  logic [WORD_W-1:0] wordData,
  input  logic              modeWide,
  input  logic              modeInterleave,
  input  logic              nibbleRight,
  output logic [PIX_W-1:0]  pixOut
);
  logic [WORD_W-1:0]     wordReg;
  shiftMode_e            modeReg;
  shiftMode_e            modeNext;
  logic [PLANE_BITS-1:0] plane [PLANES];
  logic [PIX_W-1:0]      planarPix, packedPix, widePix;
  logic [PLANE_BITS-1:0] loPlane, hiPlane, nibPlane;
  logic [1:0]            pairIdx;

  always_comb begin
    if (modeWide)            modeNext = nibbleRight ? SH_WIDE_R : SH_WIDE_L;
    else if (modeInterleave) modeNext = SH_PACKED;
    else                     modeNext = SH_PLANAR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordReg <= '0;
      modeReg <= SH_PLANAR;
    end else if (ctl.load) begin
      wordReg <= wordData;
      modeReg <= modeNext;
    end
  end

  for (genvar n = 0; n < PLANES; n++) begin : g_plane
    assign plane[n]     = wordReg[n*PLANE_BITS +: PLANE_BITS];
    assign planarPix[n] = plane[n][~ctl.slot];
  end

  assign pairIdx = ctl.slot[1:0];
  assign loPlane = ctl.slot[2] ? plane[1] : plane[0];
  assign hiPlane = ctl.slot[2] ? plane[3] : plane[2];
  assign packedPix = {hiPlane[~{pairIdx, 1'b0}], hiPlane[~{pairIdx, 1'b1}],
                      loPlane[~{pairIdx, 1'b0}], loPlane[~{pairIdx, 1'b1}]};

  assign nibPlane = plane[ctl.slot[2:1]];
  always_comb begin
    if ((modeReg == SH_WIDE_R) ^ ctl.slot[0]) widePix = nibPlane[3:0];
    else                                      widePix = nibPlane[7:4];
  end

  always_comb begin
    pixOut = '0;
    if (ctl.active) begin
      unique case (modeReg)
        SH_PLANAR:            pixOut = planarPix;
        SH_PACKED:            pixOut = packedPix;
        SH_WIDE_L, SH_WIDE_R: pixOut = widePix;
        default:              pixOut = '0;
      endcase
    end
  end

  // R8: mode and word are held unless a load happens
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.load |=> ($stable(modeReg) && $stable(wordReg)));
endmodule

// File: rtl/plane_pixel_shifter.sv
module plane_pixel_shifter
  import pxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output logic              wordReady,
  input  logic              modeWide,
  input  logic              modeInterleave,
  input  logic              nibbleRight,
  output logic [PIX_W-1:0]  pixOut,
  output logic              pixValid
);
  shiftCtl_t ctl;

  pxs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wordValid (wordValid),
    .wordReady (wordReady),
    .ctl       (ctl)
  );

  pxs_datapath u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl            (ctl),
    .wordData       (wordData),
    .modeWide       (modeWide),
    .modeInterleave (modeInterleave),
    .nibbleRight    (nibbleRight),
    .pixOut         (pixOut)
  );

  assign pixValid = ctl.active;

  // R9: idle output is zero
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pixValid |-> (pixOut == '0));

  // R7: while not on the last pixel, ready stays low and valid persists
  p_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pixValid && !wordReady) |=> pixValid);
endmodule

// File: tb/tb_plane_pixel_shifter.sv
`timescale 1ns/100ps
module tb_plane_pixel_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic        wordReady;
  logic        modeWide = 1'b0, modeInterleave = 1'b0, nibbleRight = 1'b0;
  logic [3:0]  pixOut;
  logic        pixValid;

  int checks = 0;
  int fails  = 0;
  logic  running = 1'b0;
  logic [3:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  plane_pixel_shifter dut (
    .clk(clk), .rst_n(rst_n), .wordValid(wordValid), .wordData(wordData),
    .wordReady(wordReady), .modeWide(modeWide), .modeInterleave(modeInterleave),
    .nibbleRight(nibbleRight), .pixOut(pixOut), .pixValid(pixValid)
  );

  task automatic check(string tag, logic ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] expPix(logic [31:0] w, logic wide, logic inter,
                                        logic right, int k);
    logic [3:0] p;
    logic [7:0] b, lo, hi;
    int sh;
    p = '0;
    if (wide) begin
      b = w[8*(k/2) +: 8];
      if ((k % 2 == 0) != right) p = b[7:4];
      else                       p = b[3:0];
    end else if (inter) begin
      lo = w[8*(k/4) +: 8];
      hi = w[8*(k/4 + 2) +: 8];
      sh = 6 - 2*(k % 4);
      p  = {hi[sh +: 2], lo[sh +: 2]};
    end else begin
      for (int n = 0; n < 4; n++) p[n] = w[8*n + 7 - k];
    end
    return p;
  endfunction

  task automatic sendWord(logic [31:0] w, logic wide, logic inter, logic right, string tag);
    logic rdy;
    string t;
    wordData = w; modeWide = wide; modeInterleave = inter; nibbleRight = right;
    wordValid = 1'b1;
    forever begin
      rdy = wordReady;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    #1;
    if (tag != "") t = tag;
    else if (wide && inter) t = "R6";
    else if (wide) t = right ? "R5" : "R4";
    else if (inter) t = "R3";
    else t = "R2";
    for (int k = 0; k < 8; k++) begin
      expQ.push_back(expPix(w, wide, inter, right, k));
      tagQ.push_back(t);
    end
    @(negedge clk);
    wordValid = 1'b0;
    wordData  = ~w;
    modeWide = ~wide; modeInterleave = ~inter; nibbleRight = ~right;
  endtask

  // Monitor: compares every cycle away from the active edge
  always @(negedge clk) begin
    if (running) begin
      if (expQ.size() > 0) begin
        check("R7", pixValid === 1'b1, int'(pixValid), 1);
        if (pixValid === 1'b1) begin
          logic [3:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, pixOut === e, int'(pixOut), int'(e));
        end
      end else begin
        check("R9", pixValid === 1'b0 && pixOut === 4'h0,
              int'({pixValid, pixOut}), 0);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1", pixValid === 1'b0, int'(pixValid), 0);
    check("R1", pixOut === 4'h0, int'(pixOut), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", wordReady === 1'b1, int'(wordReady), 1);
    running = 1'b1;

    // single words, idle between
    sendWord(32'hA53C_F00F, 1'b0, 1'b0, 1'b0, "");
    repeat (10) @(negedge clk);
    sendWord(32'h1B2C_3D4E, 1'b0, 1'b1, 1'b0, "");
    repeat (10) @(negedge clk);
    sendWord(32'h6745_2301, 1'b1, 1'b0, 1'b0, "");
    repeat (10) @(negedge clk);
    sendWord(32'h6745_2301, 1'b1, 1'b0, 1'b1, "");
    repeat (10) @(negedge clk);
    sendWord(32'h6745_2301, 1'b1, 1'b1, 1'b0, "");
    repeat (10) @(negedge clk);
    sendWord(32'hFEDC_BA98, 1'b1, 1'b1, 1'b1, "R6");
    repeat (10) @(negedge clk);

    // back-to-back words with mode changes at each boundary (R8, R10)
    sendWord(32'h8001_7F02, 1'b0, 1'b0, 1'b0, "R8");
    sendWord(32'hC3C3_5A5A, 1'b0, 1'b1, 1'b0, "R10");
    sendWord(32'h0F1E_2D3C, 1'b1, 1'b0, 1'b1, "R8");
    sendWord(32'h9876_5432, 1'b1, 1'b0, 1'b0, "R10");
    sendWord(32'hFFFF_0000, 1'b0, 1'b0, 1'b0, "R2");
    sendWord(32'h0000_FFFF, 1'b0, 1'b1, 1'b0, "R3");
    repeat (20) @(negedge clk);

    check("R7", expQ.size() == 0, expQ.size(), 0);
    running = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule